// File: doc/BRIEF.md
# Byte-wide multiplexed peripheral bus sequencer

This block runs byte transfers on a narrow peripheral bus that borrows the pins of a wider multiplexed address/data bus. A requester inside the chip presents one request: a byte address, a direction, a burst length, a wait-state code and, for writes, the byte to send. The sequencer then walks the bus through its phases. First come two host-bus cycles, frame and turnaround. For each byte it then runs one address-setup cycle followed by the strobe window. After the last byte it releases the pins and returns to idle.

The address travels on the low lanes of the shared bus and the data byte on the top lane. Four active-low controls frame each transfer: chip-enable, data-strobe, write-enable and read-enable. A control-enable output and one output enable per byte lane tell the pad ring when the block is driving. When it is not driving, external pull-ups hold the controls high and the data lines float. Wait states affect the two directions differently. On a read they lengthen the strobe window. On a write they come before a single-cycle strobe. Each finished byte gives a one-cycle done pulse, and on reads the pulse carries the sampled byte.

Top module: `bytebus_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, ce_n, ds_n, wr_n and rd_n are 1, ctl_oe is 0, every bus_oe bit is 0, req_ready is 1 and done is 0.
- R2: The request is taken at the clock edge where req_valid and req_ready are both 1. The two cycles after that edge are the frame and turnaround cycles. In both, ctl_oe is 1, all four controls are 1, no bus_oe bit is set and req_ready is 0.
- R3: Byte k of a request at address A starts with exactly one setup cycle. In that cycle ce_n is 0, ds_n, wr_n and rd_n are 1, and bus_oe is 4'b0111. bus_o[23:0] carries (A+k) mod 2^24 from the setup cycle to the last strobe cycle of that byte, and ce_n stays 0 for that whole span.
- R4: On a read with wait code N (0 to 7), rd_n and ds_n are 0 for exactly N+1 consecutive cycles right after each setup cycle. During them wr_n is 1 and bus_oe[3] is 0.
- R5: On a write with wait code N, each setup cycle is followed by N cycles with all strobes high. Then comes exactly one cycle with wr_n and ds_n at 0 and rd_n at 1.
- R6: On a write, bus_o[31:24] carries the value req_wdata had at the clock edge ending that byte's setup cycle. bus_oe is 4'b1111 during the wait and strobe cycles of the byte.
- R7: On a read, bus_data_i is sampled at the clock edge that closes the last strobe cycle of a byte. done is 1 for the following cycle only, and rd_data then holds the sampled byte.
- R8: Burst field value L (0 to 15) gives L+1 byte transfers that follow one another with no gap. Each byte gives exactly one done pulse.
- R9: In the cycle after the last strobe cycle of a request, ctl_oe and every bus_oe bit are 0, all controls are 1 and req_ready is 1.
- R10: While req_ready is 0, req_valid and the request fields have no effect on the transfer in progress. In idle with req_valid at 0, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Start byte address |
| req_len | input | 4 | Burst field, bytes minus one |
| req_wait | input | 3 | Wait-state code |
| req_wdata | input | 8 | Write byte, sampled at the end of each setup cycle |
| req_ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle pulse per finished byte |
| rd_data | output | 8 | Last byte read |
| bus_o | output | 32 | Shared bus output value |
| bus_oe | output | 4 | Per-lane output enables, lane i = bits 8i+7..8i |
| bus_data_i | input | 8 | Top-lane input from the pads |
| ce_n | output | 1 | Chip-enable, active low |
| ds_n | output | 1 | Data-strobe, active low |
| wr_n | output | 1 | Write-enable, active low |
| rd_n | output | 1 | Read-enable, active low |
| ctl_oe | output | 1 | Drive enable for the four controls |

## Verification
A read of L+1 bytes with wait code N holds req_ready low for 2 + (L+1)(N+2) cycles. A write of the same size takes the same count. The frame cycle follows the accepting edge by one clock. Each setup cycle follows the previous byte's last strobe cycle by one clock, and the done for a byte lands in the cycle just after that byte's last strobe cycle. The bench steps one clock at a time from the accepting edge and builds the expected phase of every cycle from the wait code and burst length. It samples 1 ns after each rising edge, so every register on the path has settled. It supplies the next write byte in the cycle of each done pulse.

// File: rtl/bytebus_pkg.sv
package bytebus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_FRAME  = 3'd1,
      PH_TURN   = 3'd2,
      PH_SETUP  = 3'd3,
      PH_WAIT   = 3'd4,
      PH_STROBE = 3'd5
   } phase_e;

   localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/bytebus_waitcnt.sv
module bytebus_waitcnt #(
   parameter int unsigned WS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WS_W-1:0] load_val,
   output logic            zero
);
   localparam logic [WS_W-1:0] WS_ONE = WS_W'(1);

   logic [WS_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - WS_ONE;
   end

   assign zero = (cnt_q == '0);

   // R4
   wait_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> ((cnt_q + WS_ONE) == $past(cnt_q)));

endmodule

// File: rtl/bytebus_fsm.sv
module bytebus_fsm
   import bytebus_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WS_W   = 3,
   parameter int unsigned LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [WS_W-1:0]   req_wait,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] rd_lane_i,
   input  logic              wt_zero,
   output phase_e            phase_o,
   output logic              is_write_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wbyte_o,
   output logic              wt_load,
   output logic [WS_W-1:0]   wt_val,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ready_o
);
   localparam logic [WS_W-1:0]   WS_ONE   = WS_W'(1);
   localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   phase_e            ph_q, ph_d;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [WS_W-1:0]   ws_q;
   logic [DATA_W-1:0] wbyte_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;
   logic              accept;
   logic              strobe_end;

   assign accept     = (ph_q == PH_IDLE) && req_valid;
   assign strobe_end = (ph_q == PH_STROBE) && (wr_q || wt_zero);

   always_comb begin
      ph_d    = ph_q;
      wt_load = 1'b0;
      wt_val  = ws_q;
      unique case (ph_q)
         PH_IDLE:   if (req_valid) ph_d = PH_FRAME;
         PH_FRAME:  ph_d = PH_TURN;
         PH_TURN:   ph_d = PH_SETUP;
         PH_SETUP: begin
            wt_load = 1'b1;
            if (wr_q && ws_q != '0) begin
               ph_d   = PH_WAIT;
               wt_val = ws_q - WS_ONE;
            end else begin
               ph_d = PH_STROBE;
            end
         end
         PH_WAIT:   if (wt_zero) ph_d = PH_STROBE;
         PH_STROBE: begin
            if (strobe_end)
               ph_d = (left_q == '0) ? PH_IDLE : PH_SETUP;
         end
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         left_q  <= '0;
         ws_q    <= '0;
         wbyte_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         done_q <= strobe_end;
         if (accept) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            left_q <= req_len;
            ws_q   <= req_wait;
         end
         if (ph_q == PH_SETUP)
            wbyte_q <= req_wdata;
         if (strobe_end && !wr_q)
            rdata_q <= rd_lane_i;
         if (strobe_end && left_q != '0) begin
            left_q <= left_q - LEN_ONE;
            addr_q <= addr_q + ADDR_ONE;
         end
      end
   end

   assign phase_o    = ph_q;
   assign is_write_o = wr_q;
   assign addr_o     = addr_q;
   assign wbyte_o    = wbyte_q;
   assign done_o     = done_q;
   assign rdata_o    = rdata_q;
   assign ready_o    = (ph_q == PH_IDLE);

   // R2
   frame_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_FRAME) |=> (ph_q == PH_TURN));

   // R8
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && !strobe_end) |=> $stable(left_q));

   // R3
   setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SETUP) |=> (ph_q == PH_WAIT || ph_q == PH_STROBE));

endmodule

// File: rtl/bytebus_lanes.sv
module bytebus_lanes
   import bytebus_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 8
) (
   input  phase_e                     phase_i,
   input  logic                       is_write_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]          wbyte_i,
   output logic [ADDR_W+DATA_W-1:0]   bus_o,
   output logic [(ADDR_W+DATA_W)/LANE_W-1:0] lane_oe_o,
   output logic                       ce_n_o,
   output logic                       ds_n_o,
   output logic                       wr_n_o,
   output logic                       rd_n_o,
   output logic                       ctl_oe_o
);
   localparam int unsigned A_LANES = ADDR_W / LANE_W;
   localparam int unsigned D_LANES = DATA_W / LANE_W;

   logic addr_phase;
   logic data_phase;
   logic strobe;

   assign addr_phase = (phase_i == PH_SETUP) || (phase_i == PH_WAIT) ||
                       (phase_i == PH_STROBE);
   assign data_phase = is_write_i &&
                       ((phase_i == PH_WAIT) || (phase_i == PH_STROBE));
   assign strobe     = (phase_i == PH_STROBE);

   for (genvar i = 0; i < A_LANES; i++) begin : g_alane
      assign lane_oe_o[i]              = addr_phase;
      assign bus_o[LANE_W*i +: LANE_W] = addr_phase ? addr_i[LANE_W*i +: LANE_W]
                                                    : '0;
   end

   for (genvar j = 0; j < D_LANES; j++) begin : g_dlane
      assign lane_oe_o[A_LANES+j]                = data_phase;
      assign bus_o[LANE_W*(A_LANES+j) +: LANE_W] =
         data_phase ? wbyte_i[LANE_W*j +: LANE_W] : '0;
   end

   assign ce_n_o   = !addr_phase;
   assign ds_n_o   = !strobe;
   assign wr_n_o   = !(strobe && is_write_i);
   assign rd_n_o   = !(strobe && !is_write_i);
   assign ctl_oe_o = (phase_i != PH_IDLE);

endmodule

// File: rtl/bytebus_seq.sv
module bytebus_seq
   import bytebus_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WS_W   = 3,
   parameter int unsigned LEN_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic                              req_write,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [LEN_W-1:0]                  req_len,
   input  logic [WS_W-1:0]                   req_wait,
   input  logic [DATA_W-1:0]                 req_wdata,
   output logic                              req_ready,
   output logic                              done,
   output logic [DATA_W-1:0]                 rd_data,
   output logic [ADDR_W+DATA_W-1:0]          bus_o,
   output logic [(ADDR_W+DATA_W)/8-1:0]      bus_oe,
   input  logic [DATA_W-1:0]                 bus_data_i,
   output logic                              ce_n,
   output logic                              ds_n,
   output logic                              wr_n,
   output logic                              rd_n,
   output logic                              ctl_oe
);
   localparam int unsigned LANES = (ADDR_W + DATA_W) / LANE_W;

   if (ADDR_W % LANE_W != 0 || ADDR_W == 0) begin : g_bad_addr
      $error("bytebus_seq: ADDR_W must be a nonzero multiple of 8");
   end
   if (DATA_W % LANE_W != 0 || DATA_W == 0) begin : g_bad_data
      $error("bytebus_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (WS_W == 0 || LEN_W == 0) begin : g_bad_cnt
      $error("bytebus_seq: WS_W and LEN_W must be at least 1");
   end

   phase_e            phase;
   logic              is_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] wbyte;
   logic              wt_load;
   logic [WS_W-1:0]   wt_val;
   logic              wt_zero;

   bytebus_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WS_W   (WS_W),
      .LEN_W  (LEN_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_wait   (req_wait),
      .req_wdata  (req_wdata),
      .rd_lane_i  (bus_data_i),
      .wt_zero    (wt_zero),
      .phase_o    (phase),
      .is_write_o (is_write),
      .addr_o     (cur_addr),
      .wbyte_o    (wbyte),
      .wt_load    (wt_load),
      .wt_val     (wt_val),
      .done_o     (done),
      .rdata_o    (rd_data),
      .ready_o    (req_ready)
   );

   bytebus_waitcnt #(
      .WS_W (WS_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wt_load),
      .load_val (wt_val),
      .zero     (wt_zero)
   );

   bytebus_lanes #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_lanes (
      .phase_i    (phase),
      .is_write_i (is_write),
      .addr_i     (cur_addr),
      .wbyte_i    (wbyte),
      .bus_o      (bus_o),
      .lane_oe_o  (bus_oe),
      .ce_n_o     (ce_n),
      .ds_n_o     (ds_n),
      .wr_n_o     (wr_n),
      .rd_n_o     (rd_n),
      .ctl_oe_o   (ctl_oe)
   );

   // R4
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R4
   rd_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !bus_oe[LANES-1]);

   // R5
   wr_onecyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> wr_n);

   // R7
   rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> done);

   // R3
   ce_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> (bus_oe[0] && ctl_oe));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> req_ready);

endmodule

// File: tb/bytebus_seq_bench.sv
module bytebus_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic [2:0]  req_wait = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready;
   logic        done;
   logic [7:0]  rd_data;
   logic [31:0] bus_o;
   logic [3:0]  bus_oe;
   logic [7:0]  bus_data_i;
   logic        ce_n, ds_n, wr_n, rd_n, ctl_oe;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   bytebus_seq u_bytebus_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_wait   (req_wait),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .done       (done),
      .rd_data    (rd_data),
      .bus_o      (bus_o),
      .bus_oe     (bus_oe),
      .bus_data_i (bus_data_i),
      .ce_n       (ce_n),
      .ds_n       (ds_n),
      .wr_n       (wr_n),
      .rd_n       (rd_n),
      .ctl_oe     (ctl_oe)
   );

   // peripheral model: returns a byte derived from the address only while read-enable is low
   always_comb bus_data_i = !rd_n ? (bus_o[7:0] ^ bus_o[15:8] ^ 8'h3C) : 8'h00;

   function automatic logic [7:0] rdv(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic [7:0] wdv(input logic [23:0] a, input int k);
      return a[7:0] + 8'hC3 + 8'(k * 29);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // {ce_n, ds_n, wr_n, rd_n, ctl_oe, bus_oe, req_ready, done}
   function automatic logic [31:0] ctl_vec();
      return {21'd0, ce_n, ds_n, wr_n, rd_n, ctl_oe, bus_oe, req_ready, done};
   endfunction

   function automatic logic [31:0] mk(input logic [3:0] s, input logic oe,
                                      input logic [3:0] lanes, input logic rdy,
                                      input logic dn);
      return {21'd0, s, oe, lanes, rdy, dn};
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run_req(input logic w, input logic [23:0] a, input logic [3:0] len,
                          input logic [2:0] ws, input bit junk);
      logic [23:0] ea;
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_len   = len;
      req_wait  = ws;
      req_wdata = wdv(a, 0);
      step();
      if (junk) begin
         req_write = !w;
         req_addr  = ~a;
         req_len   = ~len;
         req_wait  = ~ws;
      end else begin
         req_valid = 1'b0;
      end
      chk("R2 frame", ctl_vec(), mk(4'b1111, 1'b1, 4'b0000, 1'b0, 1'b0));
      step();
      req_valid = 1'b0;
      chk("R2 turn R10", ctl_vec(), mk(4'b1111, 1'b1, 4'b0000, 1'b0, 1'b0));
      for (int k = 0; k <= int'(len); k++) begin
         step();
         ea = a + 24'(k);
         if (w && k > 0) req_wdata = wdv(a, k);
         chk("R3 setup R8", ctl_vec(), mk(4'b0111, 1'b1, 4'b0111, 1'b0, k > 0));
         chk("R3 addr", {8'd0, bus_o[23:0]}, {8'd0, ea});
         if (!w && k > 0) chk("R7 rdata", {24'd0, rd_data}, {24'd0, rdv(ea - 24'd1)});
         if (!w) begin
            for (int j = 0; j <= int'(ws); j++) begin
               step();
               chk("R4 read strobe", ctl_vec(), mk(4'b0010, 1'b1, 4'b0111, 1'b0, 1'b0));
               chk("R3 addr hold", {8'd0, bus_o[23:0]}, {8'd0, ea});
            end
         end else begin
            for (int j = 0; j < int'(ws); j++) begin
               step();
               chk("R5 write wait", ctl_vec(), mk(4'b0111, 1'b1, 4'b1111, 1'b0, 1'b0));
               chk("R6 wdata wait", {24'd0, bus_o[31:24]}, {24'd0, wdv(a, k)});
            end
            step();
            chk("R5 write strobe", ctl_vec(), mk(4'b0001, 1'b1, 4'b1111, 1'b0, 1'b0));
            chk("R6 wdata strobe", {24'd0, bus_o[31:24]}, {24'd0, wdv(a, k)});
            chk("R3 addr write", {8'd0, bus_o[23:0]}, {8'd0, ea});
         end
      end
      step();
      chk("R9 R8 release", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b1));
      if (!w) chk("R7 rdata last", {24'd0, rd_data}, {24'd0, rdv(a + 24'(len))});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2;
      chk("R1 in reset", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0));
      step();
      chk("R1 in reset", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0));
      rst_n = 1'b1;
      step();
      chk("R1 after reset", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0));
      chk("R1 rdata", {24'd0, rd_data}, 32'd0);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R10 idle hold", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0));
      end
      for (int ws = 0; ws < 8; ws++) begin
         run_req(1'b0, 24'h012300 + 24'(ws * 17), 4'd0, 3'(ws), ws[0]);
         run_req(1'b0, 24'h4A5B60 + 24'(ws * 5), 4'd2, 3'(ws), !ws[0]);
         run_req(1'b1, 24'h00FF10 + 24'(ws * 3), 4'd0, 3'(ws), ws[0]);
         run_req(1'b1, 24'h7E0001 + 24'(ws * 9), 4'd3, 3'(ws), !ws[0]);
      end
      run_req(1'b0, 24'hFFFFFE, 4'd3, 3'd1, 1'b0);
      run_req(1'b1, 24'hFFFFFD, 4'd4, 3'd0, 1'b1);
      run_req(1'b0, 24'h13579B, 4'd15, 3'd0, 1'b0);
      run_req(1'b1, 24'h2468AC, 4'd15, 3'd7, 1'b0);
      step();
      chk("R10 idle after", ctl_vec(), mk(4'b1111, 1'b0, 4'b0000, 1'b1, 1'b0));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule